// File: doc/BRIEF.md
# Station Address PROM Access Decoder

This block sits between a host register bus and a network controller. It takes single-cycle read and write strobes, decodes them for one of two address windows and either serves a 16-byte station address PROM held in the block or forwards the access to a separate register port. The I/O window checks access size and alignment against a dword-mode bit. The memory-mapped window picks the PROM or the register port from one address bit and does not check the mode.

PROM data travels little-endian: lane 0 of the data bus is the byte at the addressed location, and each higher lane holds the next location. Locations wrap modulo 16. Stores into the PROM take effect only while a write-enable input is high. A read that matches no legal case completes with all ones across the width of the access. An illegal write is dropped. Forwarded accesses use a valid/ready handshake. The block accepts no new strobe while a forward is outstanding.

Top module: `sap_access_decoder`

## Requirements
- R1: After reset, PROM byte k holds bits 8k+7:8k of STATION_ADDR for k below SA_BYTES and zero above it. port_valid and resp_valid are low.
- R2: Size codes are 0 for one byte, 1 for two bytes, 2 for four bytes and 3 for illegal. In the I/O window (io_sel=1) with req_addr below 0x10 and dword_mode=0, byte accesses at any address and two-byte accesses at even addresses reach the PROM. A read returns resp_valid with its data on the cycle after the strobe.
- R3: In the I/O window below 0x10 with dword_mode=1, the only legal PROM access is four bytes with req_addr[1:0]=0. Every other size or alignment is illegal.
- R4: An illegal read returns 0x000000FF for size 0, 0x0000FFFF for size 1 and 0xFFFFFFFF for size 2 or 3. An illegal write changes no PROM byte and forwards nothing.
- R5: A PROM read places location a+i on data bits 8i+7:8i for each byte of the access and returns zero in the lanes above the access width. A PROM write uses the same lanes.
- R6: A legal PROM write updates its bytes only when prom_wen=1. With prom_wen=0 the PROM keeps its contents.
- R7: PROM locations for a multi-byte access are (address + i) modulo 16, so an access that runs past byte 15 continues at byte 0.
- R8: In the I/O window, two-byte and four-byte accesses at req_addr 0x10 or above are forwarded with the full req_addr. Byte accesses there are illegal.
- R9: In the memory window (io_sel=0), req_addr[4]=0 selects PROM location req_addr[3:0] for sizes 0, 1 and 2 at any alignment, whatever dword_mode is. With req_addr[4]=1, sizes 1 and 2 are forwarded with port_addr = req_addr[3:0] and the upper address bits zero. Size 0 is illegal there.
- R10: port_valid stays high with stable address, size, write flag and write data until port_ready. For a forwarded read, port_rdata is captured on the handshake cycle and returned with resp_valid on the next cycle. Writes produce no response.
- R11: Strobes that arrive while port_valid is high are ignored. When req_rd and req_wr are both high, the access is treated as a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| io_sel | input | 1 | 1 = I/O window, 0 = memory-mapped window |
| req_rd | input | 1 | Read strobe, one cycle |
| req_wr | input | 1 | Write strobe, one cycle |
| req_addr | input | ADDR_W | Byte address of the access |
| req_size | input | 2 | Access size code (0=1B, 1=2B, 2=4B, 3=illegal) |
| req_wdata | input | 32 | Write data, little-endian lanes |
| dword_mode | input | 1 | Selects the 32-bit-only PROM rule in the I/O window |
| prom_wen | input | 1 | Allows PROM writes |
| resp_valid | output | 1 | Read completion |
| resp_rdata | output | 32 | Read data |
| port_valid | output | 1 | Forwarded access pending |
| port_ready | input | 1 | Register port accepts the access |
| port_addr | output | ADDR_W | Forwarded address |
| port_size | output | 2 | Forwarded size code |
| port_wr | output | 1 | Forwarded access is a write |
| port_wdata | output | 32 | Forwarded write data |
| port_rdata | input | 32 | Register-port read data, valid with port_ready |

## Verification
A corrupted PROM byte shows in the data of the next read that covers it, one cycle after that read's strobe. A lane or wrap error shows as bytes in the wrong positions. A wrong route decision shows in the same cycle in one of three ways: a missing or extra port_valid, an all-ones word in place of PROM data, or a byte changed by a write that should have been dropped. A forwarder stuck busy stops every later response. A forwarder that releases early changes port fields before port_ready, or returns data on a cycle with no handshake.

// File: rtl/sap_pkg.sv
package sap_pkg;
  localparam int LANES = 4;
  localparam int DW    = 8 * LANES;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_BAD  = 2'd3
  } acc_size_e;

  typedef enum logic [1:0] {
    RT_NONE = 2'd0,
    RT_PROM = 2'd1,
    RT_PORT = 2'd2
  } route_e;

  function automatic logic [LANES-1:0] lane_en(acc_size_e s);
    case (s)
      SZ_BYTE: lane_en = 4'b0001;
      SZ_HALF: lane_en = 4'b0011;
      default: lane_en = 4'b1111;
    endcase
  endfunction

  function automatic logic [DW-1:0] fill_ones(acc_size_e s);
    case (s)
      SZ_BYTE: fill_ones = 32'h0000_00FF;
      SZ_HALF: fill_ones = 32'h0000_FFFF;
      default: fill_ones = 32'hFFFF_FFFF;
    endcase
  endfunction
endpackage

// File: rtl/sap_route_dec.sv
module sap_route_dec
  import sap_pkg::*;
#(
  parameter int ADDR_W = 5,
  parameter int IDX_W  = 4
) (
  input  logic              io_sel,
  input  logic [ADDR_W-1:0] addr,
  input  acc_size_e         size,
  input  logic              dword_mode,
  output route_e            route,
  output logic [IDX_W-1:0]  idx,
  output logic [ADDR_W-1:0] fwd_addr
);
  logic low_area;
  logic wide;

  assign low_area = (addr[ADDR_W-1:IDX_W] == '0);
  assign wide     = (size == SZ_HALF) || (size == SZ_WORD);
  assign idx      = addr[IDX_W-1:0];

  always_comb begin
    route    = RT_NONE;
    fwd_addr = addr;
    if (io_sel) begin
      if (low_area) begin
        if (!dword_mode && size == SZ_BYTE)
          route = RT_PROM;
        else if (!dword_mode && size == SZ_HALF && !addr[0])
          route = RT_PROM;
        else if (dword_mode && size == SZ_WORD && addr[1:0] == 2'b00)
          route = RT_PROM;
      end else if (wide) begin
        route = RT_PORT;
      end
    end else begin
      fwd_addr = ADDR_W'(addr[IDX_W-1:0]);
      if (!addr[IDX_W]) begin
        if (size != SZ_BAD) route = RT_PROM;
      end else if (wide) begin
        route = RT_PORT;
      end
    end
  end
endmodule

// File: rtl/sap_prom.sv
module sap_prom
  import sap_pkg::*;
#(
  parameter int DEPTH     = 16,
  parameter int IDX_W     = $clog2(DEPTH),
  parameter int INIT_BYTES = 6,
  parameter logic [8*INIT_BYTES-1:0] INIT = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] idx,
  input  acc_size_e        size,
  input  logic [DW-1:0]    wdata,
  output logic [DW-1:0]    rdata
);
  localparam logic [8*DEPTH-1:0] INIT_PAD = (8*DEPTH)'(INIT);

  logic [7:0]       mem_q [DEPTH];
  logic [IDX_W-1:0] lidx  [LANES];
  logic [LANES-1:0] en;

  assign en = lane_en(size);

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign lidx[l] = idx + IDX_W'(l);
    assign rdata[8*l +: 8] = en[l] ? mem_q[lidx[l]] : 8'h00;
  end

  for (genvar k = 0; k < DEPTH; k++) begin : g_byte
    localparam logic [7:0] RST_VAL = INIT_PAD[8*k +: 8];
    logic       hit;
    logic [7:0] nxt;

    always_comb begin
      hit = 1'b0;
      nxt = mem_q[k];
      for (int l = 0; l < LANES; l++) begin
        if (wr_en && en[l] && lidx[l] == IDX_W'(k)) begin
          hit = 1'b1;
          nxt = wdata[8*l +: 8];
        end
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   mem_q[k] <= RST_VAL;
      else if (hit) mem_q[k] <= nxt;
    end
  end
endmodule

// File: rtl/sap_port_fwd.sv
module sap_port_fwd
  import sap_pkg::*;
#(
  parameter int ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              launch,
  input  logic [ADDR_W-1:0] l_addr,
  input  logic [1:0]        l_size,
  input  logic              l_wr,
  input  logic [DW-1:0]     l_wdata,
  output logic              port_valid,
  input  logic              port_ready,
  output logic [ADDR_W-1:0] port_addr,
  output logic [1:0]        port_size,
  output logic              port_wr,
  output logic [DW-1:0]     port_wdata,
  output logic              done_rd
);
  logic vld_q, vld_d;

  always_comb begin
    vld_d = vld_q;
    if (launch)                  vld_d = 1'b1;
    else if (vld_q && port_ready) vld_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld_q <= 1'b0;
    else        vld_q <= vld_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      port_addr  <= '0;
      port_size  <= '0;
      port_wr    <= 1'b0;
      port_wdata <= '0;
    end else if (launch) begin
      port_addr  <= l_addr;
      port_size  <= l_size;
      port_wr    <= l_wr;
      port_wdata <= l_wdata;
    end
  end

  assign port_valid = vld_q;
  assign done_rd    = vld_q && port_ready && !port_wr;
endmodule

// File: rtl/sap_access_decoder.sv
module sap_access_decoder
  import sap_pkg::*;
#(
  parameter int ADDR_W     = 5,
  parameter int PROM_DEPTH = 16,
  parameter int SA_BYTES   = 6,
  parameter logic [8*SA_BYTES-1:0] STATION_ADDR = 48'h02_00_00_00_00_01
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              io_sel,
  input  logic              req_rd,
  input  logic              req_wr,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [1:0]        req_size,
  input  logic [31:0]       req_wdata,
  input  logic              dword_mode,
  input  logic              prom_wen,
  output logic              resp_valid,
  output logic [31:0]       resp_rdata,
  output logic              port_valid,
  input  logic              port_ready,
  output logic [ADDR_W-1:0] port_addr,
  output logic [1:0]        port_size,
  output logic              port_wr,
  output logic [31:0]       port_wdata,
  input  logic [31:0]       port_rdata
);
  localparam int IDX_W = $clog2(PROM_DEPTH);

  acc_size_e         size;
  route_e            route;
  logic [IDX_W-1:0]  idx;
  logic [ADDR_W-1:0] fwd_addr;
  logic [DW-1:0]     prom_rdata;
  logic              accept, is_rd, is_wr, prom_we, launch, done_rd;
  logic              rsp_load;
  logic [DW-1:0]     rsp_d;

  assign size = acc_size_e'(req_size);

  sap_route_dec #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_dec (
    .io_sel(io_sel), .addr(req_addr), .size(size), .dword_mode(dword_mode),
    .route(route), .idx(idx), .fwd_addr(fwd_addr)
  );

  assign accept  = (req_rd || req_wr) && !port_valid;
  assign is_rd   = req_rd;
  assign is_wr   = req_wr && !req_rd;
  assign prom_we = accept && is_wr && route == RT_PROM && prom_wen;
  assign launch  = accept && route == RT_PORT;

  sap_prom #(.DEPTH(PROM_DEPTH), .IDX_W(IDX_W), .INIT_BYTES(SA_BYTES),
             .INIT(STATION_ADDR)) u_prom (
    .clk(clk), .rst_n(rst_n), .wr_en(prom_we), .idx(idx), .size(size),
    .wdata(req_wdata), .rdata(prom_rdata)
  );

  sap_port_fwd #(.ADDR_W(ADDR_W)) u_fwd (
    .clk(clk), .rst_n(rst_n), .launch(launch), .l_addr(fwd_addr),
    .l_size(req_size), .l_wr(is_wr), .l_wdata(req_wdata),
    .port_valid(port_valid), .port_ready(port_ready), .port_addr(port_addr),
    .port_size(port_size), .port_wr(port_wr), .port_wdata(port_wdata),
    .done_rd(done_rd)
  );

  always_comb begin
    rsp_load = (accept && is_rd && route != RT_PORT) || done_rd;
    if (done_rd)              rsp_d = port_rdata;
    else if (route == RT_PROM) rsp_d = prom_rdata;
    else                      rsp_d = fill_ones(size);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) resp_valid <= 1'b0;
    else        resp_valid <= rsp_load;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        resp_rdata <= '0;
    else if (rsp_load) resp_rdata <= rsp_d;
  end
endmodule

// File: rtl/sap_access_decoder_chk.sv
module sap_access_decoder_chk #(
  parameter int ADDR_W = 5,
  parameter int IDX_W  = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              io_sel,
  input logic              req_rd,
  input logic              req_wr,
  input logic [ADDR_W-1:0] req_addr,
  input logic [1:0]        req_size,
  input logic              dword_mode,
  input logic              resp_valid,
  input logic [31:0]       resp_rdata,
  input logic              port_valid,
  input logic              port_ready,
  input logic [ADDR_W-1:0] port_addr,
  input logic [1:0]        port_size,
  input logic              port_wr,
  input logic [31:0]       port_wdata,
  input logic [31:0]       port_rdata
);
  logic io_low;
  assign io_low = (req_addr >> IDX_W) == '0;

  assert_reg_byte_ones_R8: assert property (@(posedge clk) disable iff (!rst_n)
    io_sel && req_rd && !port_valid && req_size == 2'd0 && !io_low
    |=> resp_valid && resp_rdata == 32'h0000_00FF);

  assert_dword_half_ones_R3: assert property (@(posedge clk) disable iff (!rst_n)
    io_sel && dword_mode && req_rd && !port_valid && req_size == 2'd1 && io_low
    |=> resp_valid && resp_rdata == 32'h0000_FFFF);

  assert_mem_byte_ones_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !io_sel && req_addr[IDX_W] && req_rd && !port_valid && req_size == 2'd0
    |=> resp_valid && resp_rdata == 32'h0000_00FF);

  assert_fwd_wide_only_R8: assert property (@(posedge clk) disable iff (!rst_n)
    port_valid |-> (port_size == 2'd1 || port_size == 2'd2));

  assert_fwd_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    port_valid && !port_ready |=> port_valid && $stable(port_addr) &&
    $stable(port_size) && $stable(port_wr) && $stable(port_wdata));

  assert_fwd_rdata_R10: assert property (@(posedge clk) disable iff (!rst_n)
    port_valid && port_ready && !port_wr |=> resp_valid && resp_rdata == $past(port_rdata));

  assert_busy_no_resp_R11: assert property (@(posedge clk) disable iff (!rst_n)
    port_valid && !port_ready |=> !resp_valid);

  assert_fwd_from_strobe_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(port_valid) |-> $past(req_rd || req_wr));
endmodule

bind sap_access_decoder sap_access_decoder_chk #(
  .ADDR_W(ADDR_W), .IDX_W($clog2(PROM_DEPTH))
) u_chk (
  .clk(clk), .rst_n(rst_n), .io_sel(io_sel), .req_rd(req_rd), .req_wr(req_wr),
  .req_addr(req_addr), .req_size(req_size), .dword_mode(dword_mode),
  .resp_valid(resp_valid), .resp_rdata(resp_rdata), .port_valid(port_valid),
  .port_ready(port_ready), .port_addr(port_addr), .port_size(port_size),
  .port_wr(port_wr), .port_wdata(port_wdata), .port_rdata(port_rdata)
);

// File: tb/sim_sap_access_decoder.sv
module sim_sap_access_decoder;
  localparam logic [47:0] SA = 48'hA1B2_C3D4_E5F6;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        io_sel, req_rd, req_wr, dword_mode, prom_wen;
  logic [4:0]  req_addr;
  logic [1:0]  req_size;
  logic [31:0] req_wdata;
  logic        resp_valid;
  logic [31:0] resp_rdata;
  logic        port_valid, port_wr;
  logic        port_ready;
  logic [4:0]  port_addr;
  logic [1:0]  port_size;
  logic [31:0] port_wdata, port_rdata;

  int checks = 0;
  int failures = 0;
  int port_delay = 0;
  int wcnt = 0;
  bit done = 0;

  logic [7:0]  model [16];
  logic [31:0] exp_q[$];
  string       tag_q[$];
  logic [39:0] fwd_q[$];
  string       ftag_q[$];

  always #4 clk = ~clk;

  sap_access_decoder #(.ADDR_W(5), .PROM_DEPTH(16), .SA_BYTES(6),
                       .STATION_ADDR(SA)) u0 (
    .clk(clk), .rst_n(rst_n), .io_sel(io_sel), .req_rd(req_rd), .req_wr(req_wr),
    .req_addr(req_addr), .req_size(req_size), .req_wdata(req_wdata),
    .dword_mode(dword_mode), .prom_wen(prom_wen), .resp_valid(resp_valid),
    .resp_rdata(resp_rdata), .port_valid(port_valid), .port_ready(port_ready),
    .port_addr(port_addr), .port_size(port_size), .port_wr(port_wr),
    .port_wdata(port_wdata), .port_rdata(port_rdata)
  );

  task automatic chk(bit ok, string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int nbytes(logic [1:0] sz);
    return (sz == 2'd0) ? 1 : (sz == 2'd1) ? 2 : 4;
  endfunction

  function automatic logic [31:0] ones(logic [1:0] sz);
    return (sz == 2'd0) ? 32'hFF : (sz == 2'd1) ? 32'hFFFF : 32'hFFFF_FFFF;
  endfunction

  function automatic logic [31:0] pdata(logic [4:0] a);
    return {8'h5A, 19'd0, a};
  endfunction

  // 0 = illegal, 1 = PROM, 2 = register port (from R2, R3, R8, R9)
  function automatic int route(bit io, logic [4:0] a, logic [1:0] sz, bit dw);
    if (io) begin
      if (a < 5'h10) begin
        if (!dw && sz == 2'd0) return 1;
        if (!dw && sz == 2'd1 && !a[0]) return 1;
        if (dw && sz == 2'd2 && a[1:0] == 2'b00) return 1;
        return 0;
      end
      return (sz == 2'd1 || sz == 2'd2) ? 2 : 0;
    end
    if (!a[4]) return (sz != 2'd3) ? 1 : 0;
    return (sz == 2'd1 || sz == 2'd2) ? 2 : 0;
  endfunction

  function automatic logic [31:0] prom_exp(logic [3:0] i, logic [1:0] sz);
    logic [31:0] v = '0;
    for (int b = 0; b < nbytes(sz); b++) v[8*b +: 8] = model[4'(i + 4'(b))];
    return v;
  endfunction

  task automatic mwrite(logic [3:0] i, logic [1:0] sz, logic [31:0] wd);
    for (int b = 0; b < nbytes(sz); b++) model[4'(i + 4'(b))] = wd[8*b +: 8];
  endtask

  task automatic acc(bit io, bit rd, logic [4:0] a, logic [1:0] sz,
                     logic [31:0] wd, bit dw, bit wen, string tag);
    int r;
    logic [4:0] fa;
    @(negedge clk);
    io_sel = io; req_addr = a; req_size = sz; req_wdata = wd;
    dword_mode = dw; prom_wen = wen; req_rd = rd; req_wr = !rd;
    r  = route(io, a, sz, dw);
    fa = io ? a : {1'b0, a[3:0]};
    if (rd) begin
      if (r == 1) begin exp_q.push_back(prom_exp(a[3:0], sz)); tag_q.push_back(tag); end
      else if (r == 2) begin
        fwd_q.push_back({fa, sz, 1'b0, wd}); ftag_q.push_back(tag);
        exp_q.push_back(pdata(fa)); tag_q.push_back(tag);
      end else begin exp_q.push_back(ones(sz)); tag_q.push_back(tag); end
    end else begin
      if (r == 1 && wen) mwrite(a[3:0], sz, wd);
      else if (r == 2) begin fwd_q.push_back({fa, sz, 1'b1, wd}); ftag_q.push_back(tag); end
    end
    @(negedge clk);
    req_rd = 1'b0; req_wr = 1'b0;
    while (port_valid) @(negedge clk);
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && resp_valid) begin
      if (exp_q.size() == 0) chk(1'b0, "R11 unexpected response", resp_rdata, 0);
      else begin
        logic [31:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk(resp_rdata === e, t, resp_rdata, e);
      end
    end
  end

  // register-port responder
  always @(negedge clk) begin
    if (!rst_n) begin
      port_ready = 1'b0; wcnt = 0; port_rdata = '0;
    end else if (port_valid && !port_ready) begin
      if (wcnt >= port_delay) begin
        port_ready = 1'b1;
        port_rdata = pdata(port_addr);
        wcnt = 0;
        if (fwd_q.size() == 0)
          chk(1'b0, "R4 unexpected forward", {port_addr, port_size, port_wr, port_wdata}, 0);
        else begin
          logic [39:0] f;
          string t;
          f = fwd_q.pop_front();
          t = ftag_q.pop_front();
          chk({port_addr, port_size, port_wr, port_wdata} === f, t,
              {port_addr, port_size, port_wr, port_wdata}, f);
        end
      end else wcnt++;
    end else port_ready = 1'b0;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    for (int k = 0; k < 16; k++) model[k] = (k < 6) ? SA[8*k +: 8] : 8'h00;
    rst_n = 1'b0; io_sel = 1'b1; req_rd = 1'b0; req_wr = 1'b0; req_addr = '0;
    req_size = '0; req_wdata = '0; dword_mode = 1'b0; prom_wen = 1'b0;
    repeat (3) @(negedge clk);
    chk(resp_valid === 1'b0, "R1 resp_valid at reset", resp_valid, 0);
    chk(port_valid === 1'b0, "R1 port_valid at reset", port_valid, 0);
    rst_n = 1'b1;

    for (int k = 0; k < 16; k++) acc(1, 1, 5'(k), 2'd0, 0, 0, 0, "R1 R2 reset byte");
    acc(1, 1, 5'h02, 2'd1, 0, 0, 0, "R2 R5 half even");
    acc(1, 1, 5'h03, 2'd1, 0, 0, 0, "R4 half odd");
    acc(1, 1, 5'h00, 2'd1, 0, 1, 0, "R3 half in dword mode");
    acc(1, 1, 5'h05, 2'd0, 0, 1, 0, "R3 byte in dword mode");
    acc(1, 1, 5'h04, 2'd2, 0, 1, 0, "R3 R5 word aligned");
    acc(1, 1, 5'h02, 2'd2, 0, 1, 0, "R3 word misaligned");
    acc(1, 1, 5'h00, 2'd2, 0, 0, 0, "R4 word in word mode");
    acc(1, 1, 5'h00, 2'd3, 0, 0, 0, "R4 size code 3");
    acc(1, 1, 5'h12, 2'd0, 0, 0, 0, "R8 byte in register area");

    acc(1, 0, 5'h06, 2'd0, 32'h55, 0, 0, "R6 write disabled");
    acc(1, 1, 5'h06, 2'd0, 0, 0, 0, "R6 read after disabled write");
    acc(1, 0, 5'h06, 2'd0, 32'h55, 0, 1, "R6 write enabled");
    acc(1, 1, 5'h06, 2'd0, 0, 0, 0, "R6 read after enabled write");
    acc(1, 0, 5'h08, 2'd1, 32'h1234, 0, 1, "R5 half write");
    acc(1, 1, 5'h08, 2'd2, 0, 1, 0, "R5 word readback");
    acc(1, 0, 5'h00, 2'd1, 32'hBEEF, 1, 1, "R4 illegal write");
    acc(1, 1, 5'h00, 2'd0, 0, 0, 0, "R4 byte unchanged");
    acc(1, 1, 5'h01, 2'd0, 0, 0, 0, "R4 byte unchanged");
    acc(1, 0, 5'h11, 2'd0, 32'h11, 0, 1, "R4 illegal register write");
    acc(1, 0, 5'h0C, 2'd2, 32'hDDCC_BBAA, 1, 1, "R5 word write");
    acc(1, 1, 5'h0E, 2'd1, 0, 0, 0, "R5 half readback");

    acc(0, 1, 5'h0E, 2'd2, 0, 1, 0, "R7 R9 wrapping word read");
    acc(0, 1, 5'h03, 2'd0, 0, 1, 0, "R9 byte ignores mode");
    acc(0, 0, 5'h0F, 2'd2, 32'h4433_2211, 1, 1, "R7 wrapping word write");
    acc(0, 1, 5'h0F, 2'd0, 0, 0, 0, "R7 byte 15");
    acc(0, 1, 5'h00, 2'd2, 0, 0, 0, "R7 R9 bytes 0-3");
    acc(0, 1, 5'h13, 2'd0, 0, 0, 0, "R9 byte at register side");
    acc(0, 0, 5'h13, 2'd0, 32'h99, 0, 1, "R9 byte write dropped");

    port_delay = 0;
    acc(0, 1, 5'h16, 2'd1, 0, 0, 0, "R9 R10 forwarded half read");
    port_delay = 2;
    acc(1, 1, 5'h14, 2'd2, 0, 1, 0, "R8 R10 forwarded word read");
    port_delay = 1;
    acc(1, 0, 5'h1A, 2'd1, 32'hCAFE, 0, 0, "R8 R10 forwarded write");
    acc(0, 0, 5'h1C, 2'd2, 32'h0BAD_F00D, 0, 0, "R9 forwarded write");

    // R11: strobes during a pending forward
    port_delay = 3;
    @(negedge clk);
    io_sel = 1; req_addr = 5'h10; req_size = 2'd1; req_wdata = 0;
    dword_mode = 0; prom_wen = 1; req_rd = 1; req_wr = 0;
    fwd_q.push_back({5'h10, 2'd1, 1'b0, 32'h0}); ftag_q.push_back("R11 busy forward");
    exp_q.push_back(pdata(5'h10)); tag_q.push_back("R11 busy forward");
    @(negedge clk);
    req_rd = 0; req_wr = 1; req_addr = 5'h00; req_size = 2'd0; req_wdata = 32'h77;
    @(negedge clk);
    req_wr = 0; req_rd = 1; req_addr = 5'h01;
    @(negedge clk);
    req_rd = 0;
    while (port_valid) @(negedge clk);
    acc(1, 1, 5'h00, 2'd0, 0, 0, 0, "R11 write while busy ignored");

    // R11: both strobes act as a read
    @(negedge clk);
    io_sel = 1; req_addr = 5'h01; req_size = 2'd0; req_wdata = 32'h33;
    dword_mode = 0; prom_wen = 1; req_rd = 1; req_wr = 1;
    exp_q.push_back(prom_exp(4'h1, 2'd0)); tag_q.push_back("R11 both strobes read");
    @(negedge clk);
    req_rd = 0; req_wr = 0;
    acc(1, 1, 5'h01, 2'd0, 0, 0, 0, "R11 both strobes no write");

    repeat (5) @(negedge clk);
    chk(exp_q.size() == 0, "R10 missing responses", exp_q.size(), 0);
    chk(fwd_q.size() == 0, "R8 missing forwards", fwd_q.size(), 0);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule